// File: doc/BRIEF.md
# Multichannel ADC Acquisition Sequencer

This block controls a bank of parallel sigma-delta converters. After reset it writes one configuration word into each converter's control register, in turn. It then raises a common sync line for a fixed number of cycles so that every converter starts sampling at the same instant. From then on it captures data without any host command. Each data-ready strobe from the converter bank starts a sweep that reads every channel over a shared, address-selected sample bus.

Each sample is packed with its channel number into a 32-bit word and stored in a 4096-word on-chip buffer. A level-sensitive interrupt tells the host when the buffer holds at least half its capacity. The host then drains words through a one-cycle-latency read port. If a word arrives while the buffer is full, the word is discarded and a sticky overflow flag is raised. Only the host can clear that flag.

Top module: `adc_acq_seq`

## Requirements
- R1: After reset the block issues exactly one configuration write per converter. The writes are on consecutive cycles with `cfg_sel_o` ascending from 0 to 23, and `cfg_data_o` equals the `CFG_WORD` parameter (default 16'h0A5C).
- R2: The cycle after the last configuration write, `sync_o` goes high. It stays high for exactly `SYNC_CYCLES` (default 4) consecutive cycles and never rises again.
- R3: `drdy_i` has no effect during configuration or sync. No read occurs until the first `drdy_i` sampled after `sync_o` has fallen.
- R4: Each accepted `drdy_i` starts 24 consecutive read cycles (`adc_rd_o` high) with `adc_sel_o` running 0 to 23. A `drdy_i` pulse that arrives during a sweep is ignored. No host action is needed between frames.
- R5: The stored word holds the sample in bits [23:0] and the channel index in bits [28:24]. Bits [31:29] are zero.
- R6: Words leave the buffer in arrival order. `host_data_o` is updated on the clock edge that samples `host_rd_i` high. A read while the buffer is empty leaves `host_data_o` unchanged.
- R7: `irq_o` is high exactly when the buffer holds 2048 or more words, and it falls as soon as reads bring the count below 2048.
- R8: A word that arrives while the buffer holds 4096 words is discarded and sets `ovf_o`. Stored words are not disturbed.
- R9: `ovf_o` stays set until a cycle with `ovf_clr_i` high and no discarded word. A discard in the same cycle as the clear keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_o | output | 1 | Configuration write strobe |
| cfg_sel_o | output | 5 | Converter addressed by the configuration write |
| cfg_data_o | output | 16 | Control register value |
| sync_o | output | 1 | Common converter sync pulse |
| drdy_i | input | 1 | Frame data-ready strobe from the converter bank |
| adc_rd_o | output | 1 | Sample read strobe |
| adc_sel_o | output | 5 | Channel driven onto the sample bus |
| adc_data_i | input | 24 | Sample of the selected channel |
| host_rd_i | input | 1 | Host buffer read |
| host_data_o | output | 32 | Word returned to the host |
| irq_o | output | 1 | Half-full interrupt, level |
| ovf_clr_i | input | 1 | Overflow flag clear pulse |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest state to reach is a full buffer. It takes more than 170 complete frames with no host reads. Getting there shows that discarded words leave the stored contents intact. It is also the only way to test a flag clear that lands in the same cycle as a discard. The bench keeps driving frames until a frame is cut short by a full buffer. It then runs one more frame that is dropped entirely, and pulses the clear in the middle of that frame. Finally it drains the buffer and checks every word against the sample pattern for its frame and channel, skipping exactly the discarded indices.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;
  typedef enum logic [1:0] {
    SEQ_BOOT,
    SEQ_CFG,
    SEQ_SYNC,
    SEQ_RUN
  } seq_state_e;

  typedef enum logic {
    RD_IDLE,
    RD_SWEEP
  } rd_state_e;
endpackage

// File: rtl/adc_cfg_seq.sv
module adc_cfg_seq
  import adc_acq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 24,
  parameter int unsigned CH_W        = 5,
  parameter int unsigned CFG_W       = 16,
  parameter logic [CFG_W-1:0] CFG_WORD = 16'h0A5C,
  parameter int unsigned SYNC_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             cfg_wr_o,
  output logic [CH_W-1:0]  cfg_sel_o,
  output logic [CFG_W-1:0] cfg_data_o,
  output logic             sync_o,
  output logic             run_o
);
  localparam int unsigned CNT_MAX = (NUM_CH > SYNC_CYCLES) ? NUM_CH : SYNC_CYCLES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_BOOT;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_BOOT: begin
          state_q <= SEQ_CFG;
          cnt_q   <= '0;
        end
        SEQ_CFG: begin
          if (cnt_q == CNT_W'(NUM_CH - 1)) begin
            state_q <= SEQ_SYNC;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_SYNC: begin
          if (cnt_q == CNT_W'(SYNC_CYCLES - 1)) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SEQ_RUN;
      endcase
    end
  end

  assign cfg_wr_o   = (state_q == SEQ_CFG);
  assign cfg_sel_o  = cfg_wr_o ? cnt_q[CH_W-1:0] : '0;
  assign cfg_data_o = cfg_wr_o ? CFG_WORD : '0;
  assign sync_o     = (state_q == SEQ_SYNC);
  assign run_o      = (state_q == SEQ_RUN);
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_acq_pkg::*;
#(
  parameter int unsigned NUM_CH   = 24,
  parameter int unsigned CH_W     = 5,
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned WORD_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                drdy_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic                adc_rd_o,
  output logic [CH_W-1:0]     adc_sel_o,
  output logic                push_o,
  output logic [WORD_W-1:0]   push_word_o
);
  rd_state_e state_q;
  logic [CH_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        RD_IDLE: begin
          idx_q <= '0;
          if (run_i && drdy_i) state_q <= RD_SWEEP;
        end
        default: begin
          // strobes during a sweep are dropped
          if (idx_q == CH_W'(NUM_CH - 1)) begin
            state_q <= RD_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign adc_rd_o  = (state_q == RD_SWEEP);
  assign adc_sel_o = idx_q;
  assign push_o    = adc_rd_o;

  always_comb begin
    push_word_o = '0;
    push_word_o[SAMPLE_W-1:0]     = adc_data_i;
    push_word_o[SAMPLE_W +: CH_W] = idx_q;
  end
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_word_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] pop_word_o,
  input  logic              ovf_clr_i,
  output logic              irq_o,
  output logic              ovf_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   count_q;
  logic full, do_push, do_pop;

  assign full    = (count_q == (AW+1)'(DEPTH));
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && (count_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= push_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      count_q    <= '0;
      pop_word_o <= '0;
      ovf_o      <= 1'b0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop) begin
        rptr_q     <= rptr_q + 1'b1;
        pop_word_o <= mem[rptr_q];
      end
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      // a discard outranks a clear in the same cycle
      if (push_i && full)  ovf_o <= 1'b1;
      else if (ovf_clr_i)  ovf_o <= 1'b0;
    end
  end

  assign irq_o = (count_q >= (AW+1)'(DEPTH / 2));
endmodule

// File: rtl/adc_acq_seq.sv
module adc_acq_seq
  import adc_acq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 24,
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned FIFO_DEPTH  = 4096,
  parameter int unsigned CFG_W       = 16,
  parameter logic [CFG_W-1:0] CFG_WORD = 16'h0A5C,
  parameter int unsigned SYNC_CYCLES = 4,
  localparam int unsigned CH_W       = $clog2(NUM_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                cfg_wr_o,
  output logic [CH_W-1:0]     cfg_sel_o,
  output logic [CFG_W-1:0]    cfg_data_o,
  output logic                sync_o,
  input  logic                drdy_i,
  output logic                adc_rd_o,
  output logic [CH_W-1:0]     adc_sel_o,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  input  logic                host_rd_i,
  output logic [WORD_W-1:0]   host_data_o,
  output logic                irq_o,
  input  logic                ovf_clr_i,
  output logic                ovf_o
);
  logic run;
  logic push;
  logic [WORD_W-1:0] push_word;

  adc_cfg_seq #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .CFG_W(CFG_W),
    .CFG_WORD(CFG_WORD), .SYNC_CYCLES(SYNC_CYCLES)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_wr_o(cfg_wr_o), .cfg_sel_o(cfg_sel_o), .cfg_data_o(cfg_data_o),
    .sync_o(sync_o), .run_o(run)
  );

  adc_frame_reader #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)
  ) u_rdr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .drdy_i(drdy_i),
    .adc_data_i(adc_data_i), .adc_rd_o(adc_rd_o), .adc_sel_o(adc_sel_o),
    .push_o(push), .push_word_o(push_word)
  );

  adc_sample_fifo #(
    .WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)
  ) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .push_word_i(push_word),
    .pop_i(host_rd_i), .pop_word_o(host_data_o), .ovf_clr_i(ovf_clr_i),
    .irq_o(irq_o), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/adc_acq_seq_chk.sv
module adc_acq_seq_chk #(
  parameter int unsigned NUM_CH      = 24,
  parameter int unsigned SYNC_CYCLES = 4,
  parameter int unsigned CH_W        = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_wr_o,
  input logic [CH_W-1:0] cfg_sel_o,
  input logic            sync_o,
  input logic            adc_rd_o,
  input logic [CH_W-1:0] adc_sel_o,
  input logic            host_rd_i,
  input logic            irq_o,
  input logic            ovf_clr_i,
  input logic            ovf_o
);
  logic [15:0] sync_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_len_q <= '0;
    else if (sync_o && sync_len_q != 16'hFFFF) sync_len_q <= sync_len_q + 1'b1;
  end

  // R1
  cfg_sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |-> (32'(cfg_sel_o) < NUM_CH));
  // R1
  cfg_ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_o && $past(cfg_wr_o)) |-> ((cfg_sel_o - $past(cfg_sel_o)) == CH_W'(1)));
  // R2
  sync_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> (32'(sync_len_q) == SYNC_CYCLES));
  // R2
  sync_after_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_wr_o) |-> sync_o);
  // R3
  no_early_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_rd_o |-> (!sync_o && !cfg_wr_o && 32'(sync_len_q) == SYNC_CYCLES));
  // R4
  sweep_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_rd_o && $past(adc_rd_o) && 32'($past(adc_sel_o)) != NUM_CH - 1)
      |-> ((adc_sel_o - $past(adc_sel_o)) == CH_W'(1)));
  // R4
  sweep_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_rd_o) |-> (adc_sel_o == '0));
  // R7
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(adc_rd_o));
  // R7
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(host_rd_i));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

bind adc_acq_seq adc_acq_seq_chk #(
  .NUM_CH(NUM_CH), .SYNC_CYCLES(SYNC_CYCLES), .CH_W(CH_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_o(cfg_wr_o), .cfg_sel_o(cfg_sel_o),
  .sync_o(sync_o), .adc_rd_o(adc_rd_o), .adc_sel_o(adc_sel_o),
  .host_rd_i(host_rd_i), .irq_o(irq_o), .ovf_clr_i(ovf_clr_i), .ovf_o(ovf_o)
);

// File: tb/adc_acq_seq_bench.sv
module adc_acq_seq_bench;
  localparam int NCH   = 24;
  localparam int DEPTH = 4096;

  typedef struct packed {
    int   frames;
    int   reads;
    logic irq;
  } vec_t;

  // fill/drain steps from an empty buffer, with the expected interrupt level
  localparam vec_t VEC [6] = '{
    '{85, 0,    1'b0},
    '{1,  0,    1'b1},
    '{0,  16,   1'b1},
    '{0,  1,    1'b0},
    '{1,  0,    1'b1},
    '{0,  2071, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic drdy_i = 1'b0, host_rd_i = 1'b0, ovf_clr_i = 1'b0;
  logic cfg_wr_o, sync_o, adc_rd_o, irq_o, ovf_o;
  logic [4:0] cfg_sel_o, adc_sel_o;
  logic [15:0] cfg_data_o;
  logic [23:0] adc_data_i;
  logic [31:0] host_data_o;

  int checks = 0, fails = 0;
  int frm_tag = 0;
  int rd_idx = 0;
  int rd_cycles = 0;

  always #5 clk_i = ~clk_i;

  assign adc_data_i = {frm_tag[15:0], 3'b000, adc_sel_o};

  always @(negedge clk_i) if (adc_rd_o) rd_cycles++;

  adc_acq_seq u_adc_acq_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_o(cfg_wr_o), .cfg_sel_o(cfg_sel_o),
    .cfg_data_o(cfg_data_o), .sync_o(sync_o), .drdy_i(drdy_i), .adc_rd_o(adc_rd_o),
    .adc_sel_o(adc_sel_o), .adc_data_i(adc_data_i), .host_rd_i(host_rd_i),
    .host_data_o(host_data_o), .irq_o(irq_o), .ovf_clr_i(ovf_clr_i), .ovf_o(ovf_o)
  );

  function automatic logic [31:0] exp_word(int k);
    logic [4:0] ch;
    int fr;
    ch = 5'(k % NCH);
    fr = k / NCH;
    return {3'b000, ch, fr[15:0], 3'b000, ch};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(bit extra_strobe, bit clr_mid);
    @(negedge clk_i); drdy_i = 1'b1;
    @(negedge clk_i); drdy_i = 1'b0;
    repeat (9) @(negedge clk_i);
    if (extra_strobe) drdy_i = 1'b1;
    if (clr_mid) ovf_clr_i = 1'b1;
    @(negedge clk_i); drdy_i = 1'b0; ovf_clr_i = 1'b0;
    repeat (16) @(negedge clk_i);
    frm_tag++;
  endtask

  task automatic read_burst(int n, string req);
    logic [31:0] bad_act, bad_exp;
    bit bad;
    bad = 0; bad_act = '0; bad_exp = '0;
    for (int i = 0; i < n; i++) begin
      host_rd_i = 1'b1;
      @(negedge clk_i);
      host_rd_i = 1'b0;
      if (!bad && host_data_o !== exp_word(rd_idx)) begin
        bad = 1; bad_act = host_data_o; bad_exp = exp_word(rd_idx);
      end
      rd_idx++;
    end
    chk(req, bad ? bad_act : 32'd0, bad ? bad_exp : 32'd0);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int waitc, rc0, nwr, sync_len;
    logic [31:0] hold;
    bit cfg_bad;

    // reset state
    drdy_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R2 reset sync", {31'd0, sync_o}, 32'd0);
    chk("R3 reset read", {31'd0, adc_rd_o}, 32'd0);
    chk("R7 reset irq", {31'd0, irq_o}, 32'd0);
    chk("R9 reset ovf", {31'd0, ovf_o}, 32'd0);
    rst_ni = 1'b1;

    // R1: configuration writes, drdy held high throughout
    waitc = 0;
    while (!cfg_wr_o && waitc < 8) begin @(negedge clk_i); waitc++; end
    cfg_bad = 0; nwr = 0;
    for (int i = 0; i < NCH; i++) begin
      if (!cfg_wr_o || cfg_sel_o != 5'(i) || cfg_data_o != 16'h0A5C) cfg_bad = 1;
      if (cfg_wr_o) nwr++;
      @(negedge clk_i);
    end
    chk("R1 cfg sequence", {31'd0, cfg_bad}, 32'd0);
    chk("R1 cfg count", nwr, NCH);
    chk("R1 cfg ends", {31'd0, cfg_wr_o}, 32'd0);

    // R2: sync length, R3: drdy ignored
    sync_len = 0;
    for (int i = 0; i < 4; i++) begin
      if (sync_o) sync_len++;
      if (i == 3) drdy_i = 1'b0;
      @(negedge clk_i);
    end
    chk("R2 sync length", sync_len, 4);
    chk("R2 sync released", {31'd0, sync_o}, 32'd0);
    repeat (6) @(negedge clk_i);
    chk("R3 no read before first drdy", rd_cycles, 0);
    chk("R2 sync single", {31'd0, sync_o}, 32'd0);

    // table: fill and drain, interrupt level (R4 R5 R6 R7)
    for (int v = 0; v < 6; v++) begin
      for (int f = 0; f < VEC[v].frames; f++) frame(1'b0, 1'b0);
      if (VEC[v].reads > 0) read_burst(VEC[v].reads, "R5 R6 word stream");
      @(negedge clk_i);
      chk($sformatf("R7 irq step %0d", v), {31'd0, irq_o}, {31'd0, VEC[v].irq});
    end
    chk("R4 read cycles per frame", rd_cycles, 87 * NCH);

    // R6: read on empty leaves data unchanged
    hold = host_data_o;
    host_rd_i = 1'b1; @(negedge clk_i); host_rd_i = 1'b0; @(negedge clk_i);
    chk("R6 empty read holds", host_data_o, hold);

    // R8: fill past capacity, last 8 words of frame 171 dropped
    for (int f = 0; f < 171; f++) frame(1'b0, 1'b0);
    chk("R8 overflow flag", {31'd0, ovf_o}, 32'd1);
    chk("R7 irq when full", {31'd0, irq_o}, 32'd1);
    // R9: clear during discards keeps flag
    frame(1'b0, 1'b1);
    chk("R9 clear loses to discard", {31'd0, ovf_o}, 32'd1);
    @(negedge clk_i); ovf_clr_i = 1'b1; @(negedge clk_i); ovf_clr_i = 1'b0;
    chk("R9 clear", {31'd0, ovf_o}, 32'd0);
    read_burst(DEPTH, "R8 contents intact");
    @(negedge clk_i);
    chk("R7 irq after drain", {31'd0, irq_o}, 32'd0);
    rd_idx += 8 + NCH;

    // R4: extra strobe mid-sweep ignored
    rc0 = rd_cycles;
    frame(1'b1, 1'b0);
    repeat (4) @(negedge clk_i);
    chk("R4 strobe during sweep ignored", rd_cycles - rc0, NCH);
    read_burst(NCH, "R5 word after overflow");
    chk("R9 stays clear", {31'd0, ovf_o}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule